// File: doc/BRIEF.md
# Reconfiguration Port Master with Hang Recovery

This block drives the dynamic reconfiguration port of a transceiver on behalf of user logic. A user request carries an address, a write flag and write data. The block takes a request only while it is idle. It then raises the port enable for exactly one cycle, with the port write enable raised in the same cycle for a write. After that it waits for the port's ready response. When ready arrives, the block returns a one-cycle done pulse. A read also returns the data that was on the port's read bus in the ready cycle.

A port that never answers is treated as hung. If no ready appears within a bounded window after the enable cycle, the block drives a dedicated port reset for a fixed number of cycles. It then waits through a short idle gap and finishes the transaction with a done pulse that carries an error flag. Every later transaction therefore starts on a port that has been reset. The user side shares the port clock, and the block never has more than one transaction in flight.

Top module: `cfgport_master`

## Requirements
- R1: `req_ready` is high exactly while the block is idle. A request sampled with `req_valid` and `req_ready` both high produces `port_en` in the following cycle. A request presented while the block is busy is not taken.
- R2: `port_en` is high for exactly one cycle per accepted request.
- R3: `port_we` is high only together with `port_en`, and it equals the request's write flag (1 = write, 0 = read). In the enable cycle, `port_addr` and `port_wdata` carry the request's address and data.
- R4: No second `port_en` is issued until the current transaction has seen ready or has completed its hang recovery.
- R5: If `port_rdy` is high in cycle k after the enable cycle (cycle 0), `done` pulses for one cycle in cycle k+1 with `err` = 0. For a read, `rdata` equals the value of `port_rdata` in cycle k. For a write, `rdata` is 0.
- R6: `port_rdy` has no effect when no response is awaited, that is while idle, in the enable cycle, or during recovery. No `done` follows from it.
- R7: If `port_rdy` stays low through cycles 1 to TIMEOUT_CYC (default 500) after the enable cycle, `port_rst` is high from cycle TIMEOUT_CYC+1 for RST_CYC cycles (default 4). It is never high at the same time as `port_en`.
- R8: After the reset pulse, RST_GAP idle cycles (default 2) follow. Then `done` pulses with `err` = 1 and `rdata` = 0, which with the defaults is in cycle 507, and the block returns to idle.
- R9: A synchronous active-high `rst` returns the block to idle. In the following cycle `port_en`, `port_we`, `port_rst` and `done` are low and `req_ready` is high. A ready that belongs to the abandoned transaction and arrives later is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, shared by the user side |
| rst | input | 1 | Synchronous active-high controller reset |
| req_valid | input | 1 | User request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (11) | Register address |
| req_wdata | input | DATA_W (16) | Write data |
| req_ready | output | 1 | Block idle, request will be taken |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | With done: transaction timed out |
| rdata | output | DATA_W (16) | With done: read data |
| port_en | output | 1 | Port enable strobe |
| port_we | output | 1 | Port write enable strobe |
| port_addr | output | ADDR_W (11) | Port address bus |
| port_wdata | output | DATA_W (16) | Port write data bus |
| port_rdy | input | 1 | Port ready response |
| port_rdata | input | DATA_W (16) | Port read data bus |
| port_rst | output | 1 | Port reset pulse |

## Verification
A wrong sequencer phase shows up at the ports within one cycle. It appears as a strobe lasting two cycles, an enable issued during a wait, `req_ready` high while busy, or a done pulse whose timing is off by one relative to ready. A wrong wait-window count cannot be seen until the window closes. The bench therefore measures the cycle of the first `port_rst`, the pulse length and the done cycle of a hung transaction exactly. An error in the captured request or the returned data is visible in the enable cycle or the done cycle of the same transaction.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_STROBE  = 3'd1,
    PH_WAIT    = 3'd2,
    PH_RECOVER = 3'd3,
    PH_GAP     = 3'd4
  } phase_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic int unsigned count_bits(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

  function automatic logic limit_hit(input int unsigned cnt, input int unsigned lim);
    return cnt >= lim;
  endfunction

  // cycle (enable cycle = 0) in which the error completion appears
  function automatic int unsigned hang_report_cycle(input int unsigned tmo,
                                                    input int unsigned pulse,
                                                    input int unsigned gap);
    return tmo + pulse + gap + 1;
  endfunction

endpackage

// File: rtl/cfgport_span.sv
module cfgport_span
  import cfgport_pkg::*;
#(
  parameter int unsigned MAXV = 500,
  parameter int unsigned CW   = count_bits(MAXV)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          advance,
  output logic [CW-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (restart) begin
      count <= CW'(1);
    end else if (advance && (count != CW'(MAXV))) begin
      count <= count + CW'(1);
    end
  end

  assert_span_bound_R7: assert property (@(posedge clk) disable iff (rst)
    32'(count) <= MAXV);

endmodule

// File: rtl/cfgport_seq.sv
module cfgport_seq
  import cfgport_pkg::*;
#(
  parameter int unsigned TIMEOUT = 500,
  parameter int unsigned PULSE   = 4,
  parameter int unsigned GAP     = 2,
  parameter int unsigned CW      = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_fire,
  input  logic          port_rdy,
  input  logic [CW-1:0] count,
  output phase_e        phase,
  output logic          restart,
  output logic          advance,
  output logic          ev_resp,
  output logic          ev_report
);

  phase_e phase_n;

  always_comb begin
    phase_n   = phase;
    restart   = 1'b0;
    advance   = 1'b0;
    ev_resp   = 1'b0;
    ev_report = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        if (req_fire) phase_n = PH_STROBE;
      end
      PH_STROBE: begin
        phase_n = PH_WAIT;
        restart = 1'b1;
      end
      PH_WAIT: begin
        if (port_rdy) begin
          ev_resp = 1'b1;
          phase_n = PH_IDLE;
        end else if (limit_hit(32'(count), TIMEOUT)) begin
          phase_n = PH_RECOVER;
          restart = 1'b1;
        end else begin
          advance = 1'b1;
        end
      end
      PH_RECOVER: begin
        if (limit_hit(32'(count), PULSE)) begin
          phase_n = PH_GAP;
          restart = 1'b1;
        end else begin
          advance = 1'b1;
        end
      end
      PH_GAP: begin
        if (limit_hit(32'(count), GAP)) begin
          ev_report = 1'b1;
          phase_n   = PH_IDLE;
        end else begin
          advance = 1'b1;
        end
      end
      default: phase_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_IDLE;
    else     phase <= phase_n;
  end

  assert_strobe_leads_wait_R2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_STROBE) |=> (phase == PH_WAIT));

  assert_recover_from_wait_R7: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_RECOVER && $past(phase) != PH_RECOVER) |-> ($past(phase) == PH_WAIT));

  assert_gap_after_recover_R8: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_GAP && $past(phase) != PH_GAP) |-> ($past(phase) == PH_RECOVER));

endmodule

// File: rtl/cfgport_portio.sv
module cfgport_portio
  import cfgport_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  phase_e            phase,
  input  logic              req_fire,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              ev_resp,
  input  logic              ev_report,
  input  logic [DATA_W-1:0] port_rdata,
  output logic              port_en,
  output logic              port_we,
  output logic [ADDR_W-1:0] port_addr,
  output logic [DATA_W-1:0] port_wdata,
  output logic              port_rst,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rdata
);

  logic wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q       <= 1'b0;
      port_addr  <= '0;
      port_wdata <= '0;
    end else if (req_fire) begin
      wr_q       <= req_write;
      port_addr  <= req_addr;
      port_wdata <= req_wdata;
    end
  end

  assign port_en  = (phase == PH_STROBE);
  assign port_we  = port_en && wr_q;
  assign port_rst = (phase == PH_RECOVER);

  always_ff @(posedge clk) begin
    if (rst) begin
      done  <= 1'b0;
      err   <= 1'b0;
      rdata <= '0;
    end else begin
      done <= ev_resp || ev_report;
      if (ev_resp) begin
        err   <= 1'b0;
        rdata <= wr_q ? '0 : port_rdata;
      end else if (ev_report) begin
        err   <= 1'b1;
        rdata <= '0;
      end
    end
  end

  assert_we_inside_en_R3: assert property (@(posedge clk) disable iff (rst)
    port_we |-> port_en);

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_error_zero_data_R8: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (rdata == '0));

  assert_rst_excludes_en_R7: assert property (@(posedge clk) disable iff (rst)
    port_rst |-> !port_en);

endmodule

// File: rtl/cfgport_master.sv
module cfgport_master
  import cfgport_pkg::*;
#(
  parameter int unsigned ADDR_W      = 11,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned TIMEOUT_CYC = 500,
  parameter int unsigned RST_CYC     = 4,
  parameter int unsigned RST_GAP     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rdata,
  output logic              port_en,
  output logic              port_we,
  output logic [ADDR_W-1:0] port_addr,
  output logic [DATA_W-1:0] port_wdata,
  input  logic              port_rdy,
  input  logic [DATA_W-1:0] port_rdata,
  output logic              port_rst
);

  localparam int unsigned SPAN_MAX = max3(TIMEOUT_CYC, RST_CYC, RST_GAP);
  localparam int unsigned CW       = count_bits(SPAN_MAX);

  // named internal events
  phase_e        phase;
  logic [CW-1:0] count;
  logic          restart;
  logic          advance;
  logic          ev_resp;
  logic          ev_report;
  logic          req_fire;

  assign req_ready = (phase == PH_IDLE);
  assign req_fire  = req_valid && req_ready;

  cfgport_span #(
    .MAXV (SPAN_MAX),
    .CW   (CW)
  ) u_span (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .advance (advance),
    .count   (count)
  );

  cfgport_seq #(
    .TIMEOUT (TIMEOUT_CYC),
    .PULSE   (RST_CYC),
    .GAP     (RST_GAP),
    .CW      (CW)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_fire  (req_fire),
    .port_rdy  (port_rdy),
    .count     (count),
    .phase     (phase),
    .restart   (restart),
    .advance   (advance),
    .ev_resp   (ev_resp),
    .ev_report (ev_report)
  );

  cfgport_portio #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_portio (
    .clk        (clk),
    .rst        (rst),
    .phase      (phase),
    .req_fire   (req_fire),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .ev_resp    (ev_resp),
    .ev_report  (ev_report),
    .port_rdata (port_rdata),
    .port_en    (port_en),
    .port_we    (port_we),
    .port_addr  (port_addr),
    .port_wdata (port_wdata),
    .port_rst   (port_rst),
    .done       (done),
    .err        (err),
    .rdata      (rdata)
  );

  assert_accept_strobes_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> port_en);

  assert_single_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    port_en |=> !port_en);

  assert_no_issue_busy_R4: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_WAIT || phase == PH_RECOVER || phase == PH_GAP) |=> !port_en);

  assert_stray_ready_R6: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE || phase == PH_STROBE || phase == PH_RECOVER) |=> !done);

  assert_timeout_entry_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(port_rst) |-> ($past(phase) == PH_WAIT && 32'($past(count)) == TIMEOUT_CYC));

  assert_reset_quiet_R9: assert property (@(posedge clk)
    rst |=> (!port_en && !port_we && !port_rst && !done && req_ready));

endmodule

// File: tb/cfgport_master_test.sv
`timescale 1ns/1ps
module cfgport_master_test;

  localparam int TMO = 500;
  localparam int PUL = 4;
  localparam int GP  = 2;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write;
  logic [10:0] req_addr;
  logic [15:0] req_wdata;
  logic        req_ready, done, err;
  logic [15:0] rdata;
  logic        port_en, port_we, port_rst, port_rdy;
  logic [10:0] port_addr;
  logic [15:0] port_wdata, port_rdata;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cfgport_master uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .done(done), .err(err), .rdata(rdata), .port_en(port_en), .port_we(port_we),
    .port_addr(port_addr), .port_wdata(port_wdata), .port_rdy(port_rdy),
    .port_rdata(port_rdata), .port_rst(port_rst)
  );

  // port model: ready arrives resp_lat cycles after the enable cycle, 0 = never
  int          resp_lat = 6;
  logic        spur_rdy = 1'b0;
  logic [9:0]  cd;
  logic [15:0] mem [16];
  logic [15:0] shadow [16];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 16; i++) mem[i] <= '0;
      cd <= '0;
    end else begin
      if (port_en && port_we) mem[port_addr[3:0]] <= port_wdata;
      if (port_en) cd <= 10'(resp_lat);
      else if (cd != 0) cd <= cd - 10'd1;
    end
  end

  assign port_rdy   = (cd == 10'd1) || spur_rdy;
  assign port_rdata = mem[port_addr[3:0]];

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one transaction with full cycle accounting; enable cycle is cycle 0
  task automatic run_txn(input logic w, input logic [10:0] a, input logic [15:0] d,
                         input int lat);
    int k = 0, rst_first = -1, rst_len = 0, en_extra = 0, exp_k;
    logic [15:0] exp_rd;
    bit seen = 0;
    resp_lat = lat;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    check(req_ready === 1'b1, "R1 idle ready", 32'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    check(port_en === 1'b1, "R1 enable after accept", 32'(port_en), 1);
    check(port_we === w, "R3 write enable", 32'(port_we), 32'(w));
    check(port_addr === a && port_wdata === d, "R3 addr/data",
          {5'd0, port_addr, port_wdata}, {5'd0, a, d});
    exp_rd = w ? 16'h0 : shadow[a[3:0]];
    if (w) shadow[a[3:0]] = d;
    while (!seen && k < 700) begin
      @(negedge clk);
      k++;
      if (port_en) en_extra++;
      if (port_rst) begin
        if (rst_first < 0) rst_first = k;
        rst_len++;
      end
      if (done) seen = 1;
    end
    check(en_extra == 0, "R2 R4 no extra enable", 32'(en_extra), 0);
    if (lat > 0) begin
      exp_k = lat + 1;
      check(k == exp_k, "R5 done cycle", 32'(k), 32'(exp_k));
      check(err === 1'b0, "R5 err low", 32'(err), 0);
      check(rdata === exp_rd, "R5 rdata", 32'(rdata), 32'(exp_rd));
      check(rst_len == 0, "R7 no port reset", 32'(rst_len), 0);
    end else begin
      exp_k = TMO + PUL + GP + 1;
      check(rst_first == TMO + 1, "R7 reset start", 32'(rst_first), TMO + 1);
      check(rst_len == PUL, "R7 reset length", 32'(rst_len), PUL);
      check(k == exp_k, "R8 error done cycle", 32'(k), 32'(exp_k));
      check(err === 1'b1 && rdata === 16'h0, "R8 err/rdata",
            {15'd0, err, rdata}, {15'd0, 1'b1, 16'h0});
    end
    @(negedge clk);
    check(done === 1'b0, "R5 single done pulse", 32'(done), 0);
    check(req_ready === 1'b1, "R8 idle after completion", 32'(req_ready), 1);
  endtask

  // {write, addr, data, latency}
  localparam logic [35:0] VEC [8] = '{
    {1'b1, 11'h005, 16'hA5A5, 8'd6},
    {1'b0, 11'h005, 16'h0000, 8'd6},
    {1'b1, 11'h7FF, 16'hFFFF, 8'd1},
    {1'b0, 11'h7FF, 16'h0000, 8'd3},
    {1'b1, 11'h010, 16'h1234, 8'd6},
    {1'b0, 11'h010, 16'h0000, 8'd20},
    {1'b0, 11'h003, 16'h0000, 8'd6},
    {1'b1, 11'h400, 16'h0F0F, 8'd2}
  };

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) shadow[i] = '0;
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(port_en === 0 && port_we === 0 && port_rst === 0 && done === 0,
          "R9 reset strobes", {28'd0, port_en, port_we, port_rst, done}, 0);
    check(req_ready === 1'b1, "R9 reset ready", 32'(req_ready), 1);
    rst = 1'b0;

    for (int v = 0; v < 8; v++)
      run_txn(VEC[v][35], VEC[v][34:24], VEC[v][23:8], int'(VEC[v][7:0]));

    // R6: stray ready while idle
    @(negedge clk); spur_rdy = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(done === 1'b0, "R6 stray ready idle", 32'(done), 0);
    end
    spur_rdy = 1'b0;
    @(negedge clk);
    check(done === 1'b0, "R6 stray ready idle tail", 32'(done), 0);

    // R7 R8: hung read, then hung write, then recovery
    run_txn(1'b0, 11'h005, 16'h0, 0);
    run_txn(1'b1, 11'h006, 16'hBEEF, 0);
    run_txn(1'b0, 11'h006, 16'h0, 4);

    // R1 R4: request held while busy is not taken until idle
    begin
      int k = 0;
      bit seen = 0;
      resp_lat = 10;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = 11'h005; req_wdata = '0;
      @(negedge clk);
      req_addr = 11'h7FF;
      check(port_en === 1'b1, "R1 first enable", 32'(port_en), 1);
      while (!seen && k < 50) begin
        @(negedge clk);
        k++;
        if (!done) begin
          check(req_ready === 1'b0, "R1 busy not ready", 32'(req_ready), 0);
          check(port_en === 1'b0, "R4 no enable while waiting", 32'(port_en), 0);
        end else seen = 1;
      end
      check(rdata === shadow[5], "R5 first read data", 32'(rdata), 32'(shadow[5]));
      @(negedge clk);
      req_valid = 1'b0;
      check(port_en === 1'b1 && port_addr === 11'h7FF, "R1 held request issued",
            {20'd0, port_en, port_addr}, {20'd0, 1'b1, 11'h7FF});
      seen = 0; k = 0;
      while (!seen && k < 50) begin
        @(negedge clk); k++;
        if (done) seen = 1;
      end
      check(k == 11 && rdata === shadow[15], "R5 second read",
            {k[15:0], rdata}, {16'd11, shadow[15]});
    end

    // R9: reset in the middle of a wait, late ready ignored
    resp_lat = 6;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 11'h005;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(port_en === 0 && port_rst === 0 && done === 0 && req_ready === 1,
          "R9 mid-transaction reset", {28'd0, port_en, port_rst, done, req_ready}, 1);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check(done === 1'b0, "R6 R9 late ready ignored", 32'(done), 0);
    end
    for (int i = 0; i < 16; i++) shadow[i] = '0;
    run_txn(1'b0, 11'h005, 16'h0, 6);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule